// File: doc/BRIEF.md
# Reduced-Precision Redundant Four-Point FFT

This block computes a four-point discrete Fourier transform of real 6-bit two's-complement samples and guards the result against soft errors. It does this without a full triplication of the datapath. One full-width transform produces the result. Two identical narrow transforms run beside it on the top three bits of each sample. Each narrow result is shifted back up to full width, and its low bits are filled with zeros, so that it can be compared with the wide result.

A separate decision is made for each of the four complex outputs. The full-width value is compared with the estimate from the first narrow copy, using the circular distance of each component. If that distance reaches a programmable threshold, the full-width value is treated as corrupted. It is then replaced by the estimate, but only when both narrow copies agree. Otherwise the full-width value passes through, and the output is flagged as uncorrectable.

Two masks are provided for fault injection. One flips bits of the full-width result. The other flips bits of the second narrow copy. The result is registered once, and a valid strobe accompanies it.

Top module: `rpr_fft4_top`

## Requirements
- R1: A result appears on `out_valid`/`out_data` exactly one clock after the cycle in which `in_valid` is high, and `out_valid` is high only in that cycle.
- R2: The four samples are packed into `in_samp`, with sample n in bits [6n+5:6n]. Output slot k is packed into `out_data` with its real part in bits [12k+5:12k] and its imaginary part in bits [12k+11:12k+6]. The slots hold the transform bins X0, X2, X1 and X3, in that order, where Xm = sum over n of x[n]·(−j)^(mn). Each component wraps modulo 64.
- R3: A narrow copy computes the same transform on sample bits [6n+5:6n+3] and wraps modulo 8. Its 3-bit components are widened with three zero bits below them. Any output that takes this estimate therefore has bits 2:0 clear in both components.
- R4: The distance for a component is the magnitude of the 6-bit wrapped difference between the full-width value and the widened value from the first narrow copy. The magnitude ranges from 0 to 32. When both distances of an output are below `thresh`, the full-width value is forwarded and neither flag is set.
- R5: When either distance reaches `thresh` and the two narrow copies agree, the widened estimate is forwarded and that output's `out_corr` bit is set.
- R6: When either distance reaches `thresh` and the narrow copies differ, the full-width value is forwarded and that output's `out_unc` bit is set. `out_corr` and `out_unc` are never set together for the same output.
- R7: Each output is judged on its own, so any mix of forwarded, corrected and uncorrectable outputs can appear in one result.
- R8: `inj_full` is XORed onto the full-width result, using the same layout as `out_data`. `inj_red` is XORed onto the second narrow copy: slot k real part in bits [6k+2:6k], imaginary part in bits [6k+5:6k+3].
- R9: In a cycle without `in_valid`, the next clock drives `out_valid`, `out_corr` and `out_unc` low and leaves `out_data` unchanged, whatever the other inputs are.
- R10: While reset is asserted, `out_valid`, `out_data`, `out_corr` and `out_unc` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample set valid this cycle |
| in_samp | input | 24 | Four 6-bit two's-complement samples |
| thresh | input | 6 | Unsigned distance threshold |
| inj_full | input | 48 | XOR mask on the full-width result |
| inj_red | input | 24 | XOR mask on the second narrow copy |
| out_valid | output | 1 | Result valid |
| out_data | output | 48 | Four complex outputs, 6-bit real and imaginary parts |
| out_corr | output | 4 | Output replaced by the narrow estimate |
| out_unc | output | 4 | Output suspect, but the narrow copies disagree |

## Verification
The per-output verdicts are independent, so correction of one output and an uncorrectable verdict on another can land in the same result word. A single output can also be left below the threshold while a neighbour is replaced. These cases are provoked by inputs that are multiples of eight, which makes the narrow estimate exact. Masks are then applied to several slots at once, with flipped bits chosen to fall on both sides of the threshold. One slot's narrow copy is also corrupted. A zero threshold combined with a narrow-copy mask forces every slot into one verdict or the other in the same cycle. A scoreboard judges each result word. It holds a direct DFT model that computes the wrapped bins, the widened estimates and the circular distances, so every slot's value and flags are compared together.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // number of points in one transform
  localparam int NPT = 4;

  // per-output verdict of the voter
  typedef enum logic [1:0] {
    PICK_FULL = 2'd0,
    PICK_RED  = 2'd1,
    PICK_KEEP = 2'd2
  } pick_e;

endpackage

// File: rtl/rpr_fft4_core.sv
// Four-point radix-4 DIF butterfly on real samples, twiddles 1 and -j only.
// Output slots: X0, X2, X1, X3 (bit-reversed); every component wraps at W bits.
module rpr_fft4_core #(
  parameter int W = 6
) (
  input  logic [rpr_pkg::NPT*W-1:0]   x,
  output logic [rpr_pkg::NPT*2*W-1:0] y
);
  localparam int OW = 2 * W;

  logic [W-1:0] x0, x1, x2, x3;
  logic [W-1:0] sum02, dif02, sum13, dif13;

  always_comb begin
    x0    = x[0*W +: W];
    x1    = x[1*W +: W];
    x2    = x[2*W +: W];
    x3    = x[3*W +: W];
    sum02 = x0 + x2;
    dif02 = x0 - x2;
    sum13 = x1 + x3;
    dif13 = x1 - x3;

    y = '0;
    y[0*OW +: W]     = sum02 + sum13;       // X0 real
    y[1*OW +: W]     = sum02 - sum13;       // X2 real
    y[2*OW +: W]     = dif02;               // X1 real
    y[2*OW + W +: W] = W'(0) - dif13;       // X1 imag (times -j)
    y[3*OW +: W]     = dif02;               // X3 real
    y[3*OW + W +: W] = dif13;               // X3 imag (times +j)
  end
endmodule

// File: rtl/rpr_vote.sv
// Threshold voter for one complex output.
module rpr_vote #(
  parameter int W  = 6,
  parameter int RW = 3
) (
  input  logic [2*W-1:0]  fp,
  input  logic [2*RW-1:0] ra,
  input  logic [2*RW-1:0] rb,
  input  logic [W-1:0]    th,
  output logic [2*W-1:0]  y,
  output logic            corr,
  output logic            unc
);
  import rpr_pkg::*;

  localparam int PAD = W - RW;

  logic [W-1:0] wide_re, wide_im;
  logic [W-1:0] diff_re, diff_im;
  logic [W-1:0] mag_re, mag_im;
  logic         suspect, agree;
  pick_e        pick;

  always_comb begin
    wide_re = {ra[RW-1:0], {PAD{1'b0}}};
    wide_im = {ra[2*RW-1:RW], {PAD{1'b0}}};
    diff_re = fp[W-1:0] - wide_re;
    diff_im = fp[2*W-1:W] - wide_im;
    mag_re  = diff_re[W-1] ? W'(0) - diff_re : diff_re;
    mag_im  = diff_im[W-1] ? W'(0) - diff_im : diff_im;
    suspect = (mag_re >= th) || (mag_im >= th);
    agree   = (ra == rb);

    if (!suspect)   pick = PICK_FULL;
    else if (agree) pick = PICK_RED;
    else            pick = PICK_KEEP;

    case (pick)
      PICK_RED: y = {wide_im, wide_re};
      default:  y = fp;
    endcase
    corr = (pick == PICK_RED);
    unc  = (pick == PICK_KEEP);
  end
endmodule

// File: rtl/rpr_fft4_top.sv
module rpr_fft4_top #(
  parameter int DW = 6,
  parameter int RW = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [rpr_pkg::NPT*DW-1:0]      in_samp,
  input  logic [DW-1:0]                   thresh,
  input  logic [rpr_pkg::NPT*2*DW-1:0]    inj_full,
  input  logic [rpr_pkg::NPT*2*RW-1:0]    inj_red,
  output logic                            out_valid,
  output logic [rpr_pkg::NPT*2*DW-1:0]    out_data,
  output logic [rpr_pkg::NPT-1:0]         out_corr,
  output logic [rpr_pkg::NPT-1:0]         out_unc
);
  localparam int NPT    = rpr_pkg::NPT;
  localparam int OW     = 2 * DW;
  localparam int ROW    = 2 * RW;
  localparam int NCOPY  = 2;

  // reset: asserted asynchronously, released after two clocks
  logic rst_meta_n, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  // truncated samples
  logic [NPT*RW-1:0] red_in;
  for (genvar n = 0; n < NPT; n++) begin : g_trunc
    assign red_in[n*RW +: RW] = in_samp[n*DW + DW - RW +: RW];
  end

  // full-width path
  logic [NPT*OW-1:0] full_raw, full_hit;
  rpr_fft4_core #(.W(DW)) i_full (.x(in_samp), .y(full_raw));
  assign full_hit = full_raw ^ inj_full;

  // narrow copies
  logic [NPT*ROW-1:0] red_out [NCOPY];
  for (genvar c = 0; c < NCOPY; c++) begin : g_red
    rpr_fft4_core #(.W(RW)) i_red (.x(red_in), .y(red_out[c]));
  end

  logic [NPT*ROW-1:0] red_a, red_b;
  assign red_a = red_out[0];
  assign red_b = red_out[1] ^ inj_red;

  // per-output voters
  logic [NPT*OW-1:0] vote_data;
  logic [NPT-1:0]    vote_corr, vote_unc;
  for (genvar k = 0; k < NPT; k++) begin : g_vote
    rpr_vote #(.W(DW), .RW(RW)) i_vote (
      .fp   (full_hit[k*OW +: OW]),
      .ra   (red_a[k*ROW +: ROW]),
      .rb   (red_b[k*ROW +: ROW]),
      .th   (thresh),
      .y    (vote_data[k*OW +: OW]),
      .corr (vote_corr[k]),
      .unc  (vote_unc[k])
    );
  end

  // next state
  logic              nx_valid;
  logic              data_en;
  logic [NPT-1:0]    nx_corr, nx_unc;

  always_comb begin
    nx_valid = in_valid;
    data_en  = in_valid;
    nx_corr  = in_valid ? vote_corr : '0;
    nx_unc   = in_valid ? vote_unc  : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      out_corr  <= '0;
      out_unc   <= '0;
    end else begin
      out_valid <= nx_valid;
      out_corr  <= nx_corr;
      out_unc   <= nx_unc;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  out_data <= '0;
    else if (data_en) out_data <= vote_data;
  end
endmodule

// File: rtl/rpr_fft4_chk.sv
module rpr_fft4_chk #(
  parameter int DW = 6,
  parameter int RW = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic [DW-1:0]                thresh,
  input logic [rpr_pkg::NPT*2*DW-1:0] inj_full,
  input logic [rpr_pkg::NPT*2*RW-1:0] inj_red,
  input logic                         out_valid,
  input logic [rpr_pkg::NPT*2*DW-1:0] out_data,
  input logic [rpr_pkg::NPT-1:0]      out_corr,
  input logic [rpr_pkg::NPT-1:0]      out_unc
);
  localparam int NPT = rpr_pkg::NPT;
  localparam int OW  = 2 * DW;
  localparam int PAD = DW - RW;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && out_corr == '0 && out_unc == '0));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_corr & out_unc) == '0);

  assert_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inj_full == '0 && inj_red == '0 && thresh >= DW'(29))
      |=> (out_corr == '0 && out_unc == '0));

  assert_zero_th_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && thresh == '0) |=> ((out_corr | out_unc) == '1));

  for (genvar k = 0; k < NPT; k++) begin : g_slot
    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_corr[k] |-> (out_data[k*OW +: PAD] == '0 && out_data[k*OW + DW +: PAD] == '0));
  end
endmodule

bind rpr_fft4_top rpr_fft4_chk #(.DW(DW), .RW(RW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .thresh    (thresh),
  .inj_full  (inj_full),
  .inj_red   (inj_red),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_corr  (out_corr),
  .out_unc   (out_unc)
);

// File: tb/test_rpr_fft4_top.sv
module test_rpr_fft4_top;

  typedef struct packed {
    logic [47:0] d;
    logic [3:0]  c;
    logic [3:0]  u;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_samp;
  logic [5:0]  thresh;
  logic [47:0] inj_full;
  logic [23:0] inj_red;
  logic        out_valid;
  logic [47:0] out_data;
  logic [3:0]  out_corr;
  logic [3:0]  out_unc;

  int   n_chk;
  int   n_fail;
  exp_t sb_q[$];
  exp_t last_exp;
  logic mon_on;

  rpr_fft4_top i_rpr_fft4_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
    .thresh(thresh), .inj_full(inj_full), .inj_red(inj_red),
    .out_valid(out_valid), .out_data(out_data),
    .out_corr(out_corr), .out_unc(out_unc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [23:0] pk(input int a, input int b, input int c, input int d);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  // direct DFT model with wrapping, widening and circular distance
  function automatic exp_t model(input logic [23:0] s, input logic [5:0] th,
                                 input logic [47:0] mf, input logic [23:0] mr);
    exp_t e;
    e = '0;
    for (int k = 0; k < 4; k++) begin
      int m, fre, fim, rre, rim, fr, fi, ar, ai, br, bi, wr, wi, dr, di;
      logic bad, agree;
      m = (k == 1) ? 2 : (k == 2) ? 1 : k;
      fre = 0; fim = 0; rre = 0; rim = 0;
      for (int n = 0; n < 4; n++) begin
        int xv, tv;
        xv = int'($signed(s[6*n +: 6]));
        tv = xv >>> 3;
        case ((m * n) % 4)
          0: begin fre += xv; rre += tv; end
          1: begin fim -= xv; rim -= tv; end
          2: begin fre -= xv; rre -= tv; end
          default: begin fim += xv; rim += tv; end
        endcase
      end
      fr = (fre & 63) ^ int'(mf[12*k +: 6]);
      fi = (fim & 63) ^ int'(mf[12*k + 6 +: 6]);
      ar = rre & 7;
      ai = rim & 7;
      br = ar ^ int'(mr[6*k +: 3]);
      bi = ai ^ int'(mr[6*k + 3 +: 3]);
      wr = ar << 3;
      wi = ai << 3;
      dr = (fr - wr) & 63; if (dr > 32) dr = 64 - dr;
      di = (fi - wi) & 63; if (di > 32) di = 64 - di;
      bad   = (dr >= int'(th)) || (di >= int'(th));
      agree = (ar == br) && (ai == bi);
      if (bad && agree) begin
        e.d[12*k +: 6]     = 6'(wr);
        e.d[12*k + 6 +: 6] = 6'(wi);
        e.c[k] = 1'b1;
      end else begin
        e.d[12*k +: 6]     = 6'(fr);
        e.d[12*k + 6 +: 6] = 6'(fi);
        e.u[k] = bad;
      end
    end
    return e;
  endfunction

  task automatic send(input logic [23:0] s, input logic [5:0] th,
                      input logic [47:0] mf, input logic [23:0] mr);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_samp  = s;
    thresh   = th;
    inj_full = mf;
    inj_red  = mr;
    e = model(s, th, mf, mr);
    sb_q.push_back(e);
    last_exp = e;
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: R1 latency, R2..R8 values and flags
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            chk("R1 unexpected out_valid", 64'(out_valid), 64'd0);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R2-data", 64'(out_data), 64'(e.d));
            chk("R5 out_corr", 64'(out_corr), 64'(e.c));
            chk("R6 out_unc", 64'(out_unc), 64'(e.u));
          end
        end else if (sb_q.size() != 0) begin
          chk("R1 missing out_valid", 64'(out_valid), 64'd1);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_fail = 0; mon_on = 1'b0; last_exp = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_samp = '0; thresh = '0;
    inj_full = '0; inj_red = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 out_data", 64'(out_data), 64'd0);
    chk("R10 flags", 64'({out_corr, out_unc}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R2 R4: clean transforms, high threshold, including wrap
    send(pk(3, -7, 12, 5), 6'd29, '0, '0);
    send(pk(31, 31, 31, 31), 6'd29, '0, '0);
    send(pk(-32, -32, -32, -32), 6'd29, '0, '0);
    send(pk(-1, 17, -20, 9), 6'd29, '0, '0);
    // R5 R8: bit 1 of slot 0 real flipped, exact inputs, threshold 2
    send(pk(8, 16, -8, 24), 6'd2, 48'h0000_0000_0002, '0);
    // R7: several slots at once; slot 3 imag bit 0 stays below threshold (R4)
    send(pk(8, 16, -8, 24), 6'd2, 48'h040_008_000_800, '0);
    // R6: slot 1 suspect while narrow copies disagree
    send(pk(8, -16, 0, 24), 6'd2, 48'h0000_0000_4000, 24'h000040);
    // R8 R4: narrow-copy mask alone leaves clean outputs
    send(pk(8, -16, 0, 24), 6'd2, '0, 24'h3F03F);
    idle(1);
    // R5: zero threshold, all slots replaced
    send(pk(13, -5, 22, -30), 6'd0, '0, '0);
    // R7 R6: zero threshold with slot 2 copies disagreeing
    send(pk(13, -5, 22, -30), 6'd0, 48'h123_456_789_ABC, 24'h001000);
    // R4: large flip below a large threshold passes through
    send(pk(0, 8, 16, 24), 6'd20, 48'h000_000_000_004, '0);
    idle(1);

    // R9: idle cycles with changed inputs do nothing
    @(negedge clk);
    in_valid = 1'b0; in_samp = pk(1, 2, 3, 4); thresh = '0;
    inj_full = '1; inj_red = '1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 out_valid", 64'(out_valid), 64'd0);
    chk("R9 out_data held", 64'(out_data), 64'(last_exp.d));
    chk("R9 flags", 64'({out_corr, out_unc}), 64'd0);
    idle(3);
    chk("R1 queue drained", 64'(sb_q.size()), 64'd0);
    report();
  end
endmodule